// File: doc/BRIEF.md
# Multi-Channel Receive Datapath Self-Test Controller

This block runs a self test over up to four parallel receive channels. Each channel has a short registered datapath that normally carries converter samples through a per-channel transform, an optional bit inversion followed by an additive offset. When a test run is started, every enabled channel takes its input from a shared pseudorandom word source instead of the converter. The run lasts a fixed 512 sample cycles and then stops by itself. Throughout the run, each channel's datapath output is folded into a 16-bit multiple-input signature register.

The channel outputs stay live during the run, so the pseudorandom stream can be watched on them while it executes. When the run ends, one signature is reported. It comes from the enabled channel with the lowest index, where channel 0 ranks first. The signature is returned as a low byte and a high byte, which are the two readback registers.

A control input decides where the pseudorandom generator starts each run: either from its fixed seed, or from the state it reached when the previous run ended. The signature therefore depends on the sequence history, on which channels are enabled, and on each channel's configuration.

Top module: `dp_selftest`

## Requirements
- R1: After reset, `busy`, `done`, `sigLo`, `sigHi` and every `chanOut` lane are zero, and the pseudorandom state equals the seed `23'h7FFFFF`.
- R2: Outside a run, or for a channel that is not enabled, `chanOut` lane c at each clock edge becomes ((`cfgInvert[c]` ? ~adc : adc) + offset) mod 2^11, computed from the `adcData` and `cfgOffset` lanes sampled at that same edge. Lane c occupies bits [11c+10:11c].
- R3: A `startPulse` sampled while idle, with at least one `chanEn` bit set, raises `busy` at that edge. `busy` then stays high for exactly 512 consecutive sampled cycles.
- R4: While `busy` is high, each channel that was enabled when the run was accepted takes the low 11 bits of the pseudorandom state as its source, in place of `adcData`. The channel transform of R2 is still applied, and the result appears on `chanOut` one edge later.
- R5: The pseudorandom source is the 23-bit register s. It steps once per busy cycle to {s[21:0], s[22]^s[17]}. If `restartPn` is 1 when a run is accepted, s is reloaded with the seed. If it is 0, s continues from its value at the end of the previous run.
- R6: Each channel's signature register m is cleared when a run is accepted. It is then updated 512 times, on the 512 `chanOut` values produced by the run: m ← {m[14:0],0} ^ (m[15] ? 16'h1021 : 0) ^ zero-extended output.
- R7: `done` rises one cycle after `busy` falls. At the same edge the signature `{sigHi, sigLo}` takes its new value. `done` stays high until the next accepted run, which clears it. `done` and `busy` are never high together.
- R8: The reported signature belongs to the lowest-index channel among those enabled when the run was accepted.
- R9: A `startPulse` that arrives while `busy` is high, or in the single cycle after `busy` falls, has no effect.
- R10: A `startPulse` sampled while idle with all `chanEn` bits clear starts no run. `busy` stays low, `done` is high after that edge, and the signature reads zero.
- R11: The signature outputs change only at the edge where `done` rises, or on a start that is accepted with no channel enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Requests a test run |
| chanEn | input | 4 | Channels taking part in the run, one bit per channel |
| restartPn | input | 1 | 1: reload the pseudorandom seed at start; 0: continue from the previous state |
| cfgInvert | input | 4 | Per-channel inversion of the datapath source |
| cfgOffset | input | 44 | Per-channel 11-bit additive offset, lane c at bits [11c+10:11c] |
| adcData | input | 44 | Per-channel converter samples, same lane layout |
| chanOut | output | 44 | Per-channel datapath outputs, same lane layout |
| busy | output | 1 | High during the 512 injection cycles |
| done | output | 1 | High after a run completes, until the next accepted start |
| sigLo | output | 8 | Signature bits 7:0 |
| sigHi | output | 8 | Signature bits 15:8 |

## Verification
The checker tests on every cycle the rules that can be seen at the ports alone: the exact 512-cycle busy window, acceptance of a start only when idle, the start ignored in the drain cycle, the mutual exclusion of done and busy, the empty-start outcome, and signature stability between completions. Only the bench scenarios can show that the injected words follow the pseudorandom polynomial and that each lane's transform is applied. The same holds for whether the generator resumes or restarts, for the signature value itself, and for the lowest-index selection; the bench shows these by comparing against its own models of the generator, the transform and the signature register.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

  // Strobes from the sequencer to the datapath, one cycle each unless noted
  typedef struct packed {
    logic runStart;     // run accepted: clear signatures, latch enables
    logic restartSeed;  // reload the pseudorandom seed with runStart
    logic inject;       // level: replace samples of enabled lanes
    logic capture;      // level: fold lane outputs into signatures
    logic finish;       // publish selected signature
    logic finishEmpty;  // start with no lane: publish zero
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seqState_t;

endpackage

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int RUN_LEN = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic              restartPn,
  output ctrlStrobe_t       strobe,
  output logic              busy,
  output logic              done
);

  localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RUN_LEN - 1);

  seqState_t stateQ;
  logic [CNT_W-1:0] cntQ;
  logic doneQ;
  logic idleStart;
  logic anyEn;

  assign anyEn     = |chanEn;
  assign idleStart = (stateQ == ST_IDLE) && startPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (startPulse) begin
            if (anyEn) begin
              stateQ <= ST_RUN;
              cntQ   <= '0;
              doneQ  <= 1'b0;
            end else begin
              doneQ  <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (cntQ == LAST_CNT) begin
            stateQ <= ST_DRAIN;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        ST_DRAIN: begin
          stateQ <= ST_IDLE;
          doneQ  <= 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.runStart    = idleStart && anyEn;
    strobe.restartSeed = idleStart && anyEn && restartPn;
    strobe.inject      = (stateQ == ST_RUN);
    // outputs lag injection by one register, so capture skips the first
    // run cycle and takes the drain cycle instead
    strobe.capture     = ((stateQ == ST_RUN) && (cntQ != '0)) || (stateQ == ST_DRAIN);
    strobe.finish      = (stateQ == ST_DRAIN);
    strobe.finishEmpty = idleStart && !anyEn;
  end

  assign busy = (stateQ == ST_RUN);
  assign done = doneQ;

endmodule

// File: rtl/selftest_dp.sv
module selftest_dp
  import selftest_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 11,
  parameter int PN_W     = 23,
  parameter int TAP_HI   = 22,
  parameter int TAP_LO   = 17,
  parameter logic [PN_W-1:0] PN_SEED = 23'h7FFFFF,
  parameter int SIG_W    = 16,
  parameter logic [SIG_W-1:0] SIG_POLY = 16'h1021
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  input  logic [NUM_CH-1:0]            chanEn,
  input  logic [NUM_CH-1:0]            cfgInvert,
  input  logic [NUM_CH*SAMPLE_W-1:0]   cfgOffset,
  input  logic [NUM_CH*SAMPLE_W-1:0]   adcData,
  output logic [NUM_CH*SAMPLE_W-1:0]   chanOut,
  output logic [SIG_W-1:0]             signature
);

  localparam int PAD_W = SIG_W - SAMPLE_W;
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [PN_W-1:0]     pnQ;
  logic [NUM_CH-1:0]   enQ;
  logic [SIG_W-1:0]    misrNext [NUM_CH];
  logic [SIG_W-1:0]    sigQ;
  logic [SEL_W-1:0]    selIdx;
  logic [SAMPLE_W-1:0] pnWord;

  assign pnWord = pnQ[SAMPLE_W-1:0];

  // shared pseudorandom source
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pnQ <= PN_SEED;
    end else if (strobe.restartSeed) begin
      pnQ <= PN_SEED;
    end else if (strobe.inject) begin
      pnQ <= {pnQ[PN_W-2:0], pnQ[TAP_HI] ^ pnQ[TAP_LO]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= '0;
    end else if (strobe.runStart) begin
      enQ <= chanEn;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic [SAMPLE_W-1:0] srcWord;
    logic [SAMPLE_W-1:0] shaped;
    logic [SAMPLE_W-1:0] outQ;
    logic [SIG_W-1:0]    misrQ;

    assign srcWord = (strobe.inject && enQ[c]) ? pnWord
                                               : adcData[c*SAMPLE_W +: SAMPLE_W];
    assign shaped  = (cfgInvert[c] ? ~srcWord : srcWord)
                     + cfgOffset[c*SAMPLE_W +: SAMPLE_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outQ <= '0;
      else       outQ <= shaped;
    end

    assign misrNext[c] = {misrQ[SIG_W-2:0], 1'b0}
                       ^ (misrQ[SIG_W-1] ? SIG_POLY : '0)
                       ^ {{PAD_W{1'b0}}, outQ};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                misrQ <= '0;
      else if (strobe.runStart) misrQ <= '0;
      else if (strobe.capture)  misrQ <= misrNext[c];
    end

    assign chanOut[c*SAMPLE_W +: SAMPLE_W] = outQ;
  end

  // lowest enabled index wins
  always_comb begin
    selIdx = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (enQ[c]) selIdx = SEL_W'(c);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   sigQ <= '0;
    else if (strobe.finishEmpty) sigQ <= '0;
    else if (strobe.finish)      sigQ <= misrNext[selIdx];
  end

  assign signature = sigQ;

endmodule

// File: rtl/dp_selftest.sv
module dp_selftest
  import selftest_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 11,
  parameter int RUN_LEN  = 512,
  parameter int SIG_W    = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startPulse,
  input  logic [NUM_CH-1:0]          chanEn,
  input  logic                       restartPn,
  input  logic [NUM_CH-1:0]          cfgInvert,
  input  logic [NUM_CH*SAMPLE_W-1:0] cfgOffset,
  input  logic [NUM_CH*SAMPLE_W-1:0] adcData,
  output logic [NUM_CH*SAMPLE_W-1:0] chanOut,
  output logic                       busy,
  output logic                       done,
  output logic [SIG_W/2-1:0]         sigLo,
  output logic [SIG_W/2-1:0]         sigHi
);

  localparam int HALF_W = SIG_W / 2;

  ctrlStrobe_t      strobe;
  logic [SIG_W-1:0] signature;

  selftest_seq #(
    .NUM_CH (NUM_CH),
    .RUN_LEN(RUN_LEN)
  ) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .chanEn    (chanEn),
    .restartPn (restartPn),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  selftest_dp #(
    .NUM_CH  (NUM_CH),
    .SAMPLE_W(SAMPLE_W),
    .SIG_W   (SIG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .chanEn   (chanEn),
    .cfgInvert(cfgInvert),
    .cfgOffset(cfgOffset),
    .adcData  (adcData),
    .chanOut  (chanOut),
    .signature(signature)
  );

  assign sigLo = signature[HALF_W-1:0];
  assign sigHi = signature[SIG_W-1:HALF_W];

endmodule

// File: rtl/dp_selftest_checker.sv
module dp_selftest_checker #(
  parameter int NUM_CH  = 4,
  parameter int RUN_LEN = 512,
  parameter int HALF_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic [NUM_CH-1:0] chanEn,
  input logic              busy,
  input logic              done,
  input logic [HALF_W-1:0] sigLo,
  input logic [HALF_W-1:0] sigHi
);

  localparam int RC_W = $clog2(RUN_LEN + 1) + 1;

  logic [RC_W-1:0] busyRun;
  logic            busyQ;
  logic            idleNow;
  logic            emptyAcc;
  logic            fullAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyRun <= '0;
      busyQ   <= 1'b0;
    end else begin
      busyQ   <= busy;
      busyRun <= busy ? busyRun + 1'b1 : '0;
    end
  end

  assign idleNow  = !busy && !busyQ;
  assign emptyAcc = idleNow && startPulse && (chanEn == '0);
  assign fullAcc  = idleNow && startPulse && (chanEn != '0);

  assert_busy_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < RC_W'(RUN_LEN)));

  assert_busy_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == RC_W'(RUN_LEN)));

  assert_start_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    fullAcc |=> (busy && !done));

  assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_done_after_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |=> done);

  assert_drain_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && busyQ && !busy) |=> !busy);

  assert_empty_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    emptyAcc |=> (done && !busy && sigLo == '0 && sigHi == '0));

  assert_sig_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!$rose(done) && !$past(emptyAcc)) |-> $stable({sigHi, sigLo}));

endmodule

bind dp_selftest dp_selftest_checker #(
  .NUM_CH (NUM_CH),
  .RUN_LEN(RUN_LEN),
  .HALF_W (SIG_W / 2)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .chanEn    (chanEn),
  .busy      (busy),
  .done      (done),
  .sigLo     (sigLo),
  .sigHi     (sigHi)
);

// File: tb/dp_selftest_bench.sv
module dp_selftest_bench;

  localparam int NCH = 4;
  localparam int W   = 11;
  localparam int LEN = 512;
  localparam logic [22:0] SEED = 23'h7FFFFF;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           startPulse = 1'b0;
  logic [NCH-1:0] chanEn = '0;
  logic           restartPn = 1'b0;
  logic [NCH-1:0] cfgInvert = '0;
  logic [NCH*W-1:0] cfgOffset = '0;
  logic [NCH*W-1:0] adcData = '0;
  logic [NCH*W-1:0] chanOut;
  logic busy, done;
  logic [7:0] sigLo, sigHi;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [22:0] pnModel = SEED;

  always #10 clk = ~clk;

  dp_selftest u_dp_selftest (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chanEn(chanEn),
    .restartPn(restartPn), .cfgInvert(cfgInvert), .cfgOffset(cfgOffset),
    .adcData(adcData), .chanOut(chanOut), .busy(busy), .done(done),
    .sigLo(sigLo), .sigHi(sigHi)
  );

  function automatic logic [22:0] pnStep(input logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  function automatic logic [W-1:0] xform(input logic [W-1:0] v, input logic inv,
                                         input logic [W-1:0] off);
    return (inv ? ~v : v) + off;
  endfunction

  function automatic logic [15:0] misrStep(input logic [15:0] m, input logic [W-1:0] d);
    return {m[14:0], 1'b0} ^ (m[15] ? 16'h1021 : 16'h0000) ^ {5'b0, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic randCfg();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    cfgOffset = r[NCH*W-1:0];
    cfgInvert = 4'($urandom());
  endtask

  task automatic randAdc();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    adcData = r[NCH*W-1:0];
  endtask

  // R2: idle transform on all lanes
  task automatic normalCycles(input int n);
    int errs = 0;
    logic [15:0] sigBefore;
    sigBefore = {sigHi, sigLo};
    for (int i = 0; i < n; i++) begin
      randCfg();
      randAdc();
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (chanOut[c*W +: W] != xform(adcData[c*W +: W], cfgInvert[c], cfgOffset[c*W +: W]))
          errs++;
      end
    end
    chk(errs == 0, "R2 idle lane transform", 32'(errs), 0);
    chk({sigHi, sigLo} == sigBefore, "R11 signature held while idle",
        {16'h0, sigHi, sigLo}, {16'h0, sigBefore});
  endtask

  task automatic doRun(input logic [NCH-1:0] en, input bit restart,
                       input bit pokeMid, input bit pokeDrain);
    int sel = 0;
    int busyCount = 0;
    int outErr = 0;
    logic [15:0] misr = '0;
    logic [W-1:0] word;
    string sigTag;
    randCfg();
    for (int c = NCH - 1; c >= 0; c--) if (en[c]) sel = c;
    chanEn = en;
    restartPn = restart;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (en == '0) begin
      chk(done && !busy, "R10 empty start sets done, no run", {30'h0, done, busy}, 32'h2);
      chk({sigHi, sigLo} == 16'h0, "R10 empty start signature zero",
          {16'h0, sigHi, sigLo}, 0);
      return;
    end
    chk(busy && !done, "R3 run accepted", {30'h0, busy, done}, 32'h2);
    if (restart) pnModel = SEED;
    for (int i = 0; i < LEN; i++) begin
      if (busy) busyCount++;
      word = pnModel[W-1:0];
      pnModel = pnStep(pnModel);
      randAdc();
      chanEn = 4'($urandom());
      startPulse = (pokeMid && i == 100);
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        logic [W-1:0] e;
        e = en[c] ? xform(word, cfgInvert[c], cfgOffset[c*W +: W])
                  : xform(adcData[c*W +: W], cfgInvert[c], cfgOffset[c*W +: W]);
        if (chanOut[c*W +: W] != e) outErr++;
      end
      misr = misrStep(misr, xform(word, cfgInvert[sel], cfgOffset[sel*W +: W]));
    end
    startPulse = 1'b0;
    chk(busyCount == LEN, "R3 busy length", 32'(busyCount), LEN);
    chk(!busy && !done, "R7 drain cycle", {30'h0, busy, done}, 0);
    chk(outErr == 0, "R4 injected words on live outputs", 32'(outErr), 0);
    if (pokeMid) chk(busyCount == LEN, "R9 mid-run start ignored", 32'(busyCount), LEN);
    if (pokeDrain) startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(done && !busy, "R7 done rises after busy", {30'h0, done, busy}, 32'h2);
    sigTag = restart ? "R6 R8 signature (seed restart)" : "R5 R6 R8 signature (continued)";
    chk({sigHi, sigLo} == misr, sigTag, {16'h0, sigHi, sigLo}, {16'h0, misr});
    if (pokeDrain) begin
      @(negedge clk);
      chk(done && !busy, "R9 drain-cycle start ignored", {30'h0, done, busy}, 32'h2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 reset control", {30'h0, busy, done}, 0);
    chk({sigHi, sigLo} == 16'h0, "R1 reset signature", {16'h0, sigHi, sigLo}, 0);
    chk(chanOut == '0, "R1 reset outputs", chanOut[31:0], 0);

    normalCycles(20);
    doRun(4'b0110, 1'b1, 1'b1, 1'b1);
    normalCycles(10);
    doRun(4'b1000, 1'b0, 1'b0, 1'b0);
    doRun(4'b1111, 1'b1, 1'b0, 1'b0);
    doRun(4'b1100, 1'b0, 1'b0, 1'b0);
    normalCycles(10);
    doRun(4'b0000, 1'b0, 1'b0, 1'b0);
    normalCycles(5);
    for (int k = 0; k < 3; k++) begin
      logic [NCH-1:0] en;
      en = 4'($urandom());
      if (en == '0) en = 4'b0100;
      doRun(en, 1'($urandom()), 1'b0, 1'b0);
    end
    doRun(4'b0000, 1'b1, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    end
    $finish;
  end

endmodule